// File: doc/BRIEF.md
# Mode-Selectable Synthesiser Divider Pair

This block is the digital divider pair of a frequency synthesiser. A loop divider counts pulses from one of two prescaled RF inputs and emits a one-clock pulse each time it wraps. A reference divider counts crystal clocks and pulses at a selectable comparison rate. The phase detector compares the two pulse trains. The block also gives it an enable for the charge pump's output stage.

The whole block runs on the crystal clock, nominally 4.5 MHz. Each prescaled RF input reaches it as a one-clock strobe, `fm_tick` or `am_tick`. Two mode bits choose which strobe feeds the loop divider and how the 16-bit divide word becomes a ratio:
- doubled word;
- the word itself;
- only its upper twelve bits.

A 4-bit reference code picks the comparison rate. Its top two values inhibit the loop: both dividers stop, the charge pump floats, and one of the two values also stops the crystal oscillator.

Top module: `synth_div_core`

## Requirements
- R1: With `mode_dbl`=1, only `fm_tick` is counted, and `vco_pulse` repeats every 2×`div_word` counted ticks. Strobes on `am_tick` have no effect.
- R2: With `mode_dbl`=0 and `mode_wide`=1, only `am_tick` is counted, and `vco_pulse` repeats every `div_word` ticks. Strobes on `fm_tick` have no effect.
- R3: With `mode_dbl`=0 and `mode_wide`=0, only `am_tick` is counted, and the ratio is `div_word[15:4]`. Bits [3:0] have no effect on the period.
- R4: Each divider output is high for exactly one clock. That clock is the one after the edge that sampled the terminal-count step.
- R5: A change of divide word, mode bits or reference code is applied only at the next terminal count. The interval already running completes with the old ratio.
- R6: `ref_sel` sets the reference divider ratio as 4.5 MHz divided by the comparison rate:
  - codes 0–3: 180;
  - code 4: 360;
  - codes 5, 6 and 7: 720, 1440 and 1440;
  - codes 8–10: 900;
  - code 11: 4500;
  - code 12: 1500;
  - code 13: 300.
- R7: With `ref_sel`=15, both dividers are held cleared and emit no pulse, `cp_drive_en`=0 and `osc_run`=1.
- R8: With `ref_sel`=14, the behaviour of R7 applies and in addition `osc_run`=0.
- R9: After reset, and after leaving inhibit, both counters start from zero, so each divider's first step produces a pulse at once. While reset is asserted, both pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fm_tick | input | 1 | One-clock strobe per prescaled high-band RF cycle |
| am_tick | input | 1 | One-clock strobe per prescaled low-band RF cycle |
| mode_dbl | input | 1 | 1: high-band input, doubled ratio |
| mode_wide | input | 1 | With mode_dbl=0: 1 selects the full 16-bit word, 0 selects the upper 12 bits |
| div_word | input | 16 | Loop divide word |
| ref_sel | input | 4 | Reference rate / inhibit code |
| vco_pulse | output | 1 | Loop divider terminal-count pulse |
| ref_pulse | output | 1 | Reference divider terminal-count pulse |
| cp_drive_en | output | 1 | 0 puts the charge pump output in high impedance |
| osc_run | output | 1 | 0 stops the crystal oscillator |

## Verification
A pulse appears one clock after the edge that takes the terminal-count step. The bench therefore samples on falling edges and measures each period as the number of falling edges between two pulses. For the loop divider, that count must equal the ratio times the strobe spacing. After a divide word or code change, the first interval must still show the old ratio and only the next one the new ratio. This holds because the change is made at the falling edge that first shows a pulse. On leaving inhibit, the reference pulse is due at the first falling edge after the edge that sees the new code, and it is checked there. During inhibit, the bench counts pulses over a window longer than the slowest reference period and expects zero.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    localparam int unsigned CODE_INHIBIT_OSC = 14;
    localparam int unsigned CODE_INHIBIT     = 15;

    // Comparison rate in Hz for each reference code; inhibit codes map to
    // a harmless nonzero rate because the divider is halted there.
    function automatic int unsigned ref_rate_hz(input int unsigned code);
        case (code)
            0, 1, 2, 3: ref_rate_hz = 25000;
            4:          ref_rate_hz = 12500;
            5:          ref_rate_hz = 6250;
            6, 7:       ref_rate_hz = 3125;
            8, 9, 10:   ref_rate_hz = 5000;
            11:         ref_rate_hz = 1000;
            12:         ref_rate_hz = 3000;
            13:         ref_rate_hz = 15000;
            default:    ref_rate_hz = 25000;
        endcase
    endfunction

endpackage

// File: rtl/tc_divider.sv
module tc_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         halt,
    input  logic         step,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pulse;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (halt) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (st_q.cnt == '0) begin
                st_d.pulse = 1'b1;
                st_d.cnt   = (ratio > W'(1)) ? ratio - W'(1) : '0;
            end else begin
                st_d.cnt = st_q.cnt - W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    // R4: a pulse is only ever the result of a step on the previous edge
    p_pulse_after_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(step));

    // R7: a halted divider emits nothing on the next cycle
    p_halt_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !pulse);

endmodule

// File: rtl/ref_ratio_lut.sv
module ref_ratio_lut
    import synth_div_pkg::*;
#(
    parameter int unsigned XTAL_HZ = 4500000,
    parameter int          CODE_W  = 4,
    parameter int          REF_W   = 13
) (
    input  logic [CODE_W-1:0] code,
    output logic [REF_W-1:0]  ratio
);
    localparam int NCODES = 1 << CODE_W;

    logic [REF_W-1:0] tab [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_tab
        assign tab[g] = REF_W'(XTAL_HZ / ref_rate_hz(g));
    end

    assign ratio = tab[code];

endmodule

// File: rtl/synth_div_core.sv
module synth_div_core
    import synth_div_pkg::*;
#(
    parameter int unsigned XTAL_HZ = 4500000,
    parameter int          WORD_W  = 16,
    parameter int          NARROW_DROP = 4,
    parameter int          CODE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fm_tick,
    input  logic              am_tick,
    input  logic              mode_dbl,
    input  logic              mode_wide,
    input  logic [WORD_W-1:0] div_word,
    input  logic [CODE_W-1:0] ref_sel,
    output logic              vco_pulse,
    output logic              ref_pulse,
    output logic              cp_drive_en,
    output logic              osc_run
);
    localparam int CNT_W = WORD_W + 1;
    localparam int REF_W = $clog2(XTAL_HZ / 1000 + 1);

    logic             inhibit;
    logic             loop_step;
    logic [CNT_W-1:0] loop_ratio;
    logic [REF_W-1:0] ref_ratio;

    always_comb begin
        inhibit   = (ref_sel == CODE_W'(CODE_INHIBIT)) ||
                    (ref_sel == CODE_W'(CODE_INHIBIT_OSC));
        loop_step = mode_dbl ? fm_tick : am_tick;
        if (mode_dbl)       loop_ratio = {div_word, 1'b0};
        else if (mode_wide) loop_ratio = {1'b0, div_word};
        else                loop_ratio = CNT_W'(div_word >> NARROW_DROP);
    end

    assign cp_drive_en = !inhibit;
    assign osc_run     = (ref_sel != CODE_W'(CODE_INHIBIT_OSC));

    ref_ratio_lut #(
        .XTAL_HZ(XTAL_HZ), .CODE_W(CODE_W), .REF_W(REF_W)
    ) u_lut (
        .code (ref_sel),
        .ratio(ref_ratio)
    );

    tc_divider #(.W(CNT_W)) u_loop (
        .clk  (clk),
        .rst_n(rst_n),
        .halt (inhibit),
        .step (loop_step),
        .ratio(loop_ratio),
        .pulse(vco_pulse)
    );

    tc_divider #(.W(REF_W)) u_ref (
        .clk  (clk),
        .rst_n(rst_n),
        .halt (inhibit),
        .step (1'b1),
        .ratio(ref_ratio),
        .pulse(ref_pulse)
    );

    // R8: the oscillator is never stopped while the charge pump drives
    p_osc_stop_floats_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |-> !cp_drive_en);

    // R4: every reference ratio is well above one, so pulses never abut
    p_ref_one_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    // R1: in doubled mode a loop pulse needs a high-band strobe
    p_dbl_uses_fm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vco_pulse && $past(mode_dbl)) |-> $past(fm_tick));

    // R7: a floating charge pump means the loop divider is silent next cycle
    p_float_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_drive_en |=> !vco_pulse && !ref_pulse);

endmodule

// File: tb/sim_synth_div_core.sv
module sim_synth_div_core;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LIMIT      = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fm_tick = 1'b0, am_tick = 1'b0;
    logic        mode_dbl = 1'b0, mode_wide = 1'b1;
    logic [15:0] div_word = 16'd100;
    logic [3:0]  ref_sel = 4'd0;
    logic        vco_pulse, ref_pulse, cp_drive_en, osc_run;

    int checks = 0, failures = 0;
    int fm_gap = 1, am_gap = 1;
    bit fm_on = 1'b0, am_on = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    synth_div_core u0 (
        .clk(clk), .rst_n(rst_n), .fm_tick(fm_tick), .am_tick(am_tick),
        .mode_dbl(mode_dbl), .mode_wide(mode_wide), .div_word(div_word),
        .ref_sel(ref_sel), .vco_pulse(vco_pulse), .ref_pulse(ref_pulse),
        .cp_drive_en(cp_drive_en), .osc_run(osc_run)
    );

    initial begin : tick_gen
        int fph = 0, aph = 0;
        forever begin
            @(negedge clk);
            fph = (fph + 1) % fm_gap;
            aph = (aph + 1) % am_gap;
            fm_tick = fm_on && (fph == 0);
            am_tick = am_on && (aph == 0);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit pl(input bit use_ref);
        return use_ref ? ref_pulse : vco_pulse;
    endfunction

    // Advance to the next falling edge showing a pulse; returns edges taken.
    task automatic to_pulse(input bit use_ref, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pl(use_ref) && n < LIMIT);
    endtask

    task automatic period(input bit use_ref, input string req, input int exp);
        int n;
        to_pulse(use_ref, n);
        to_pulse(use_ref, n);
        check(req, n, exp);
    endtask

    task automatic t_reset;
        check("R9 vco in reset", int'(vco_pulse), 0);
        check("R9 ref in reset", int'(ref_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 first ref pulse", int'(ref_pulse), 1);
    endtask

    task automatic t_fm;
        mode_dbl = 1'b1; div_word = 16'd150;
        fm_on = 1'b1; fm_gap = 2; am_on = 1'b1; am_gap = 1;
        period(1'b0, "R1 doubled period", 600);
        period(1'b0, "R1 doubled period again", 600);
    endtask

    task automatic t_am16;
        mode_dbl = 1'b0; mode_wide = 1'b1; div_word = 16'h01F4;
        am_gap = 3; fm_gap = 1;
        period(1'b0, "R2 wide period", 1500);
    endtask

    task automatic t_narrow;
        int n;
        mode_wide = 1'b0; div_word = 16'h00A7; am_gap = 1;
        period(1'b0, "R3 narrow period", 10);
        to_pulse(1'b0, n);
        div_word = 16'h00A0;
        period(1'b0, "R3 low nibble ignored", 10);
    endtask

    task automatic t_width;
        int n;
        am_gap = 3;
        to_pulse(1'b0, n);
        @(negedge clk);
        check("R4 vco one clock wide", int'(vco_pulse), 0);
        to_pulse(1'b1, n);
        @(negedge clk);
        check("R4 ref one clock wide", int'(ref_pulse), 0);
        period(1'b0, "R4 narrow at gap 3", 30);
    endtask

    task automatic t_change;
        int n;
        mode_wide = 1'b1; div_word = 16'd40; am_gap = 1;
        to_pulse(1'b0, n);
        to_pulse(1'b0, n);
        div_word = 16'd70;
        to_pulse(1'b0, n);
        check("R5 old word completes", n, 40);
        to_pulse(1'b0, n);
        check("R5 new word applies", n, 70);
        mode_dbl = 1'b1; fm_gap = 1;
        to_pulse(1'b0, n);
        check("R5 old mode completes", n, 70);
        to_pulse(1'b0, n);
        check("R5 new mode applies", n, 140);
    endtask

    task automatic t_ref_one(input int code, input int exp);
        int n;
        to_pulse(1'b1, n);
        ref_sel = 4'(code);
        to_pulse(1'b1, n);
        to_pulse(1'b1, n);
        check($sformatf("R6 ref code %0d", code), n, exp);
    endtask

    task automatic t_ref;
        t_ref_one(0, 180);
        t_ref_one(3, 180);
        t_ref_one(4, 360);
        t_ref_one(5, 720);
        t_ref_one(7, 1440);
        t_ref_one(9, 900);
        t_ref_one(11, 4500);
        t_ref_one(12, 1500);
        t_ref_one(13, 300);
    endtask

    task automatic t_inhibit(input int code, input int exp_osc, input string req);
        int pulses = 0;
        @(negedge clk);
        ref_sel = 4'(code);
        @(negedge clk);
        check({req, " cp drive"}, int'(cp_drive_en), 0);
        check({req, " osc"}, int'(osc_run), exp_osc);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (vco_pulse || ref_pulse) pulses++;
        end
        check({req, " no pulses"}, pulses, 0);
        ref_sel = 4'd0;
        @(negedge clk);
        check("R9 ref restart", int'(ref_pulse), 1);
        check("R7 drive restored", int'(cp_drive_en), 1);
        check("R9 vco restart", int'(vco_pulse), 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        t_fm();
        t_am16();
        t_narrow();
        t_width();
        t_change();
        t_ref();
        t_inhibit(15, 1, "R7");
        t_inhibit(14, 0, "R8");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule